// File: doc/BRIEF.md
# Conversion Start Sequencer

This block is the phase controller of a successive-approximation converter. A single active-low start line drives it. The block alternates between a conversion phase and an acquisition phase. It reports a busy flag, a two-bit phase code and a low-power flag. When a conversion ends, it captures the result word supplied by the conversion engine. The conversion itself is modelled only as a fixed number of system clocks.

The block supports two modes of operation:
- **Externally timed:** the host holds the start line high through the acquisition time, then pulls it low to launch one conversion.
- **Free-running:** the host leaves the start line low. The block then times every acquisition phase itself and relaunches a conversion after each one.

A conversion, once launched, always runs to its end. The power-down input only gates launches between conversions. A start request that arrives too early in the acquisition phase is dropped and recorded in a sticky error flag.

Top module: `conv_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `low_power`, `data_valid` and `early_err` are 0, `phase` is 2'b00 (idle) and `result_q` is 0.
- R2: A high-to-low change of `start_n` seen in idle, or after the acquisition time has elapsed, sets `busy` and `phase` to 2'b10 (convert) on the third rising clock edge after the change. `busy` then stays high for exactly CONV_CYCLES clock cycles.
- R3: While `busy` is high, further falls and rises of `start_n` neither restart the conversion nor cut it short.
- R4: Raising `pwr_dn` during a conversion does not shorten it. While `pwr_dn` is high after the conversion, no new conversion starts. When `pwr_dn` is lowered with `start_n` still low, a conversion starts on the next rising edge.
- R5: On the edge where `busy` falls, `result_q` loads `result_in`. `data_valid` is high for exactly the one cycle that follows that edge.
- R6: With `start_n` held low, conversions repeat on their own. `busy` stays low for exactly ACQ_CYCLES cycles between them.
- R7: `low_power` is 1 exactly while `phase` is 2'b01 (acquire), which is entered on every fall of `busy`. It is 0 in idle and during conversion.
- R8: A fall of `start_n` detected in the first ACQ_CYCLES-1 cycles of acquisition launches nothing, even if `start_n` then stays low. It sets `early_err`, which stays 1 until reset. A later fall after the acquisition time launches normally.
- R9: After reset, no conversion begins while `start_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Asynchronous active-low conversion start |
| pwr_dn | input | 1 | Power-down request, honoured between conversions |
| result_in | input | RES_W | Result word from the conversion engine |
| busy | output | 1 | High for the whole conversion phase |
| phase | output | 2 | 00 idle, 01 acquire, 10 convert |
| low_power | output | 1 | High during the acquisition phase |
| data_valid | output | 1 | One-cycle pulse after a conversion completes |
| result_q | output | RES_W | Last captured result |
| early_err | output | 1 | Sticky flag for a start request that came too early |

## Verification
The assertions assume that `start_n` and `pwr_dn` may change in any cycle, but only through the synchronizer-facing ports. They also assume that `result_in` is stable on the edge where `busy` falls. The stimulus changes every input on the falling clock edge and sets `result_in` at the beginning of each conversion. The bench starts early requests one cycle into acquisition, so they land well inside the forbidden window. It starts late requests only after the counter has saturated, so every case falls clearly on one side of the acquisition boundary.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ACQ  = 2'b01,
    PH_CONV = 2'b10
  } phase_e;
endpackage

// File: rtl/conv_seq_sync.sv
// Two-flop synchronizer on the start line plus falling-edge detect.
module conv_seq_sync (
  input  logic clk,
  input  logic rst,
  input  logic start_n,
  output logic lvl,
  output logic fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= start_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign fall = prev_q & ~s2_q;
endmodule

// File: rtl/conv_seq_timer.sv
// Shared phase counter: cleared on phase change, stepped while a phase runs.
module conv_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/conv_seq_result.sv
// Result capture register with a one-cycle valid pulse.
module conv_seq_result #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] din,
  output logic [RES_W-1:0] dout,
  output logic             valid
);
  logic [RES_W-1:0] dout_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) dout_q <= din;
    end
  end

  assign dout  = dout_q;
  assign valid = valid_q;

  // R5: the valid pulse lasts one cycle (loads are never back to back)
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int RES_W       = 16,
  parameter int CONV_CYCLES = 64,
  parameter int ACQ_CYCLES  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             pwr_dn,
  input  logic [RES_W-1:0] result_in,
  output logic             busy,
  output logic [1:0]       phase,
  output logic             low_power,
  output logic             data_valid,
  output logic [RES_W-1:0] result_q,
  output logic             early_err
);
  localparam int MAXC = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_CYCLES - 1);

  phase_e        state_q, state_d;
  logic          lvl, fall;
  logic [CW-1:0] cnt;
  logic          conv_end, acq_ok, launch, early_hit;
  logic          armed_q, armed_d, err_q;

  conv_seq_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .start_n (start_n),
    .lvl     (lvl),
    .fall    (fall)
  );

  conv_seq_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (launch | conv_end),
    .step  ((state_q == PH_CONV) | ((state_q == PH_ACQ) & ~acq_ok)),
    .cnt   (cnt)
  );

  conv_seq_result #(.RES_W(RES_W)) u_result (
    .clk   (clk),
    .rst   (rst),
    .load  (conv_end),
    .din   (result_in),
    .dout  (result_q),
    .valid (data_valid)
  );

  always_comb begin
    conv_end  = (state_q == PH_CONV) && (cnt == CONV_LAST);
    acq_ok    = (state_q == PH_IDLE) || ((state_q == PH_ACQ) && (cnt == ACQ_LAST));
    launch    = (state_q != PH_CONV) && acq_ok && !pwr_dn && !lvl && (armed_q || fall);
    early_hit = (state_q == PH_ACQ) && fall && !acq_ok;

    if (lvl)                  armed_d = 1'b0;
    else if (conv_end)        armed_d = 1'b1;
    else if (fall && acq_ok)  armed_d = 1'b1;
    else                      armed_d = armed_q;

    state_d = state_q;
    if (launch)        state_d = PH_CONV;
    else if (conv_end) state_d = PH_ACQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      if (early_hit) err_q <= 1'b1;
    end
  end

  assign phase     = state_q;
  assign busy      = state_q[1];
  assign low_power = state_q[0];
  assign early_err = err_q;

  // R3: a running conversion is never cut short
  p_no_abort_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != CONV_LAST) |=> busy);

  // R4: no conversion launches while power-down is requested
  p_pd_gate_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!pwr_dn));

  // R5: completion always produces the valid pulse
  p_valid_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> data_valid);

  // R7: acquisition follows every conversion and is never busy
  p_lp_after_conv_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> low_power);
  p_lp_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(low_power && busy));

  // R8: the early-start flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    early_err |=> early_err);

  // R9: leaving idle requires the synchronized start line to be low
  p_idle_start_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(phase == 2'b00) && busy) |-> $past(!lvl));
endmodule

// File: tb/conv_seq_bench.sv
module conv_seq_bench;
  localparam int W    = 8;
  localparam int CONV = 6;
  localparam int ACQ  = 8;

  logic clk = 1'b0;
  logic rst, start_n, pwr_dn;
  logic [W-1:0] result_in;
  logic busy, low_power, data_valid, early_err;
  logic [1:0] phase;
  logic [W-1:0] result_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  conv_seq #(.RES_W(W), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) u_conv_seq (
    .clk(clk), .rst(rst), .start_n(start_n), .pwr_dn(pwr_dn),
    .result_in(result_in), .busy(busy), .phase(phase), .low_power(low_power),
    .data_valid(data_valid), .result_q(result_q), .early_err(early_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin step(); n++; end while (!busy && n < 100);
  endtask

  task automatic run_len(input logic lv, output int n);
    n = 1;
    forever begin
      step();
      if (busy == lv && n < 100) n++;
      else break;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    rst = 1; start_n = 1; pwr_dn = 0; result_in = '0;
    repeat (4) step();
    // R1: reset state
    check("R1 busy", busy, 0); check("R1 phase", phase, 0);
    check("R1 lp", low_power, 0); check("R1 err", early_err, 0);
    check("R1 dv", data_valid, 0); check("R1 result", result_q, 0);
    rst = 0;
    step();
    check("R1 busy after release", busy, 0);

    // R9: idle holds while start stays high
    ok = 1;
    repeat (20) begin step(); if (busy || phase != 0 || low_power) ok = 0; end
    check("R9 idle hold", ok, 1);

    // R2: external start
    start_n = 0; result_in = 8'hA5;
    wait_rise(n);
    check("R2 launch latency", n, 3);
    check("R2 phase convert", phase, 2);
    start_n = 1;
    run_len(1'b1, n);
    check("R2 conv length", n, CONV);
    check("R5 dv", data_valid, 1); check("R5 result", result_q, 8'hA5);
    check("R7 lp in acq", low_power, 1); check("R7 phase acq", phase, 1);
    step();
    check("R5 dv one cycle", data_valid, 0);

    // R3/R4: toggling start and power-down during conversion
    repeat (12) step();
    start_n = 0; result_in = 8'h3C;
    wait_rise(n);
    n = 1;
    for (int i = 0; i < 20; i++) begin
      if (i == 0) begin pwr_dn = 1; start_n = 1; end
      if (i == 1) start_n = 0;
      if (i == 2) start_n = 1;
      if (i == 3) start_n = 0;
      step();
      if (busy) n++; else break;
    end
    check("R3 R4 conv not restarted or aborted", n, CONV);
    check("R5 result after pd", result_q, 8'h3C);
    ok = 1;
    repeat (20) begin step(); if (busy || !low_power) ok = 0; end
    check("R4 pd blocks restart", ok, 1);
    pwr_dn = 0;
    step();
    check("R4 resume after pd", busy, 1);

    // R6: free-running
    for (int k = 0; k < 3; k++) begin
      result_in = W'(8'h40 + k);
      run_len(1'b1, n);
      check("R6 conv length", n, CONV);
      check("R5 result free", result_q, 8'h40 + k);
      check("R5 dv free", data_valid, 1);
      run_len(1'b0, n);
      check("R6 acq length", n, ACQ);
    end

    // R8: early start
    start_n = 1;
    run_len(1'b1, n);
    start_n = 0;
    ok = 1;
    repeat (30) begin step(); if (busy) ok = 0; end
    check("R8 early ignored", ok, 1);
    check("R8 err set", early_err, 1);
    start_n = 1;
    repeat (3) step();
    start_n = 0;
    wait_rise(n);
    check("R8 late start accepted", n, 3);
    check("R8 err sticky", early_err, 1);

    // R1: reset clears the flag
    start_n = 1;
    rst = 1; repeat (2) step();
    check("R1 err cleared", early_err, 0);
    check("R1 idle again", phase, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule